// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a slave on a two-wire serial bus and holds a 512-byte memory array. It samples the bus clock and data lines with the fast system clock through two-flop synchronisers and finds START and STOP conditions on the synchronised lines. It drives the data line only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The block never stretches the clock. The bus has no way to pause the master, so the block offers no valid/ready interface. The only back-pressure is the busy window, during which the block refuses every address byte.

A master selects the block with an address byte. That byte carries a fixed device type, two bus-address bits that must match the strap pins, the top bit of the 9-bit memory address and the read/write flag. A write transfer then sends one word-address byte and one or more data bytes. The data bytes collect in a 16-entry page buffer, and the buffer is copied into the array only when a STOP arrives. The copy starts a programmable busy period that stands in for the nonvolatile write time. A read sends bytes from the current address, and the address advances after each byte for as long as the master acknowledges.

Top module: `twi_mem_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. An address byte clocked in without a preceding START is not acknowledged.
- R2: An address byte is taken MSB first. It is acknowledged only if bits 7..4 equal 4'b1010 and bits 3..2 equal `strap_i`. After a mismatch the block drives nothing, and it acknowledges nothing until the next START.
- R3: The block acknowledges by pulling SDA low for the ninth clock of a byte. It does this for a matching address byte and for every following word-address and data byte of a write. `sda_oe` only rises while SCL is low.
- R4: A byte write (address, word address, one data byte, STOP) stores the data byte at the 9-bit address, and a later read returns it.
- R5: Within a write, the low 4 address bits step by one after each data byte and wrap inside the 16-byte page. With more than 16 data bytes, the later bytes replace the earlier bytes that map to the same slot.
- R6: Written data reach the array only at a STOP. A START that arrives before the STOP discards the buffered bytes, and a STOP with nothing buffered starts no busy period.
- R7: After a committing STOP, the block ignores the bus for BUSY_CYCLES system clocks. It does not acknowledge during that window, and it acknowledges again once the window has ended.
- R8: A read sends the byte at the current address MSB first. After each byte the full 9-bit address steps by one, and 0x1FF wraps to 0x000.
- R9: When the master NACKs a read byte, the block releases SDA and stays passive until the next START or STOP.
- R10: Bit 1 of the address byte is bit 8 of the memory address, and the word-address byte supplies bits 7..0.
- R11: After reset, `sda_oe` is low and every memory byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Bus-address strap pins compared with address bits 3..2 |
| sda_oe | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
A wrong internal state shows up at the ports within the next byte. A bad state or address decode gives a missing or extra acknowledge on the ninth clock of the byte in progress. A bad page pointer or commit only shows when the data are read back after the busy window, on the first byte whose address was affected. A busy timer that ends early shows as an acknowledge to an address byte sent right after the STOP. A read path that fails to release the line after a NACK shows as low bits when the master clocks further bits.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_WORD,
    S_WDATA,
    S_ACK,
    S_TX,
    S_MACK,
    S_PASSIVE,
    S_BUSY
  } twi_state_e;
endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  // two-flop synchronisers, then one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
  parameter int AW = 9,
  parameter int PW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            wr_en_i,
  input  logic [PW-1:0]   wr_off_i,
  input  logic [7:0]      wr_data_i,
  input  logic            commit_i,
  input  logic [AW-PW-1:0] page_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [7:0]      rd_data_o,
  output logic            pending_o
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;

  logic [7:0]       mem [DEPTH];
  logic [7:0]       slot_dat [SLOTS];
  logic [SLOTS-1:0] slot_vld;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] d_q;
    logic       v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clear_i || commit_i) begin
        v_q <= 1'b0;
      end else if (wr_en_i && wr_off_i == PW'(g)) begin
        d_q <= wr_data_i;
        v_q <= 1'b1;
      end
    end
    assign slot_dat[g] = d_q;
    assign slot_vld[g] = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < SLOTS; i++)
        if (slot_vld[i]) mem[{page_i, PW'(i)}] <= slot_dat[i];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign pending_o = |slot_vld;

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> pending_o); // R6
  AST_NO_FILL_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && commit_i)); // R6
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_pkg::*;
#(
  parameter int BUSY_CYCLES = 5000,
  parameter int AW          = 9,
  parameter int PW          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe
);
  localparam int PGW = AW - PW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, pending;
  logic [7:0] rd_data;

  twi_state_e      state_q, nxt_q;
  logic [3:0]      cnt_q;
  logic [7:0]      sh_q;
  logic            byte_rdy_q, mack_q;
  logic [AW-1:0]   addr_q;

  logic addr_match, fill_en, commit, clear;

  twi_line_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
  );

  twi_page_store #(.AW(AW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .wr_en_i(fill_en),
    .wr_off_i(addr_q[PW-1:0]), .wr_data_i(sh_q), .commit_i(commit),
    .page_i(addr_q[AW-1:PW]), .rd_addr_i(addr_q), .rd_data_o(rd_data),
    .pending_o(pending)
  );

  assign addr_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:2] == strap_i);
  assign fill_en    = (state_q == S_WDATA) && !start_det && !stop_det
                      && scl_fall && byte_rdy_q;
  assign commit     = (state_q != S_BUSY) && stop_det && pending;
  assign clear      = (state_q != S_BUSY) && start_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      nxt_q      <= S_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      byte_rdy_q <= 1'b0;
      mack_q     <= 1'b0;
      addr_q     <= '0;
      sda_oe     <= 1'b0;
    end else if (state_q == S_BUSY) begin
      sda_oe <= 1'b0;
      if (!busy) state_q <= S_IDLE;
    end else if (start_det) begin
      state_q    <= S_ADDR;
      cnt_q      <= '0;
      byte_rdy_q <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (stop_det) begin
      state_q <= pending ? S_BUSY : S_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_WORD, S_WDATA: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 4'd7) byte_rdy_q <= 1'b1;
          end else if (scl_fall && byte_rdy_q) begin
            byte_rdy_q <= 1'b0;
            cnt_q      <= '0;
            if (state_q == S_ADDR) begin
              if (addr_match) begin
                addr_q[AW-1] <= sh_q[1];
                sda_oe       <= 1'b1;
                state_q      <= S_ACK;
                nxt_q        <= sh_q[0] ? S_TX : S_WORD;
              end else begin
                state_q <= S_PASSIVE;
              end
            end else if (state_q == S_WORD) begin
              addr_q[7:0] <= sh_q;
              sda_oe      <= 1'b1;
              state_q     <= S_ACK;
              nxt_q       <= S_WDATA;
            end else begin
              addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
              sda_oe         <= 1'b1;
              state_q        <= S_ACK;
              nxt_q          <= S_WDATA;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          state_q <= nxt_q;
          cnt_q   <= '0;
          if (nxt_q == S_TX) begin
            sh_q   <= rd_data;
            sda_oe <= !rd_data[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              sda_oe  <= 1'b0;
              state_q <= S_MACK;
              addr_q  <= addr_q + 1'b1;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b0};
              sda_oe <= !sh_q[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_q <= !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_q    <= rd_data;
              sda_oe  <= !rd_data[7];
              cnt_q   <= '0;
              state_q <= S_TX;
            end else begin
              state_q <= S_PASSIVE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUSY) |-> !sda_oe); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUSY && busy) |=> (state_q == S_BUSY)); // R7
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R6
  AST_PASSIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PASSIVE) |-> !sda_oe); // R9
endmodule

// File: tb/tb_twi_mem_target.sv
module tb_twi_mem_target;
  localparam int BUSY = 500;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] smem [512];
  logic [7:0] wbuf [32];

  always #5 clk = ~clk;

  twi_mem_target #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b);
    sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bit_rx(output logic b);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_tx(v[i]);
    bit_rx(b);
    ack = !b;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_rx(b); v[i] = b; end
    bit_tx(!ack);
  endtask

  function automatic logic [7:0] addr_byte(input logic [8:0] a, input bit rd);
    return {4'b1010, strap, a[8], rd};
  endfunction

  // bench model of a page write
  function automatic void model_write(input logic [8:0] a, input int n);
    for (int i = 0; i < n; i++) smem[{a[8:4], 4'(a[3:0] + i)}] = wbuf[i];
  endfunction

  task automatic do_write(input logic [8:0] a, input int n, input bit wait_busy);
    bit ack;
    bus_start();
    wr_byte(addr_byte(a, 1'b0), ack); chk(ack, "R3 addr ack", ack, 1);
    wr_byte(a[7:0], ack);             chk(ack, "R3 word ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      chk(ack, "R3 data ack", ack, 1);
    end
    bus_stop();
    model_write(a, n);
    if (wait_busy) wt(BUSY + 20);
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string req);
    bit ack;
    logic [7:0] v;
    logic [8:0] p;
    bus_start();
    wr_byte(addr_byte(a, 1'b0), ack);
    wr_byte(a[7:0], ack);
    bus_start();
    wr_byte(addr_byte(a, 1'b1), ack); chk(ack, "R3 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, v);
      p = a + 9'(i);
      chk(v == smem[p], req, v, smem[p]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic b;
    logic [7:0] v;
    logic [8:0] ra;
    int n;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 512; i++) smem[i] = 8'h00;
    wt(5);
    chk(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(10);
    chk(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);
    do_read(9'h000, 2, "R11 memory zero");
    do_read(9'h1C0, 1, "R11 memory zero");

    // R1: address byte without START
    bus_start(); wr_byte(8'h00, ack); bus_stop(); wt(Q);
    scl = 1'b0; wt(Q);
    wr_byte(addr_byte(9'h000, 1'b0), ack);
    chk(!ack, "R1 no ack without START", ack, 0);
    bus_stop();

    // R2: wrong device type, then line must stay released
    bus_start();
    wr_byte({4'b1011, strap, 2'b00}, ack);
    chk(!ack, "R2 wrong type nack", ack, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R2 passive after mismatch", ack, 0);
    bus_stop();
    // R2: wrong strap
    bus_start();
    wr_byte({4'b1010, ~strap, 2'b00}, ack);
    chk(!ack, "R2 wrong strap nack", ack, 0);
    bus_stop();

    // R4 / R10: byte write at 0x1A5, 0x0A5 untouched
    wbuf[0] = 8'h5C;
    do_write(9'h1A5, 1, 1'b1);
    do_read(9'h1A5, 1, "R4 byte write readback");
    do_read(9'h0A5, 1, "R10 ninth bit separates halves");

    // R7: busy window
    wbuf[0] = 8'h33;
    do_write(9'h010, 1, 1'b0);
    bus_start();
    wr_byte(addr_byte(9'h000, 1'b0), ack);
    chk(!ack, "R7 nack while busy", ack, 0);
    bus_stop();
    wt(BUSY);
    bus_start();
    wr_byte(addr_byte(9'h000, 1'b0), ack);
    chk(ack, "R7 ack after busy", ack, 1);
    bus_stop();
    do_read(9'h010, 1, "R7 busy commit data");

    // R5: 20 bytes into page 0x0F0 starting at 0x0F3
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h80 + i);
    do_write(9'h0F3, 20, 1'b1);
    do_read(9'h0F0, 16, "R5 page wrap and overwrite");

    // R6: START before STOP abandons data, no busy after
    bus_start();
    wr_byte(addr_byte(9'h040, 1'b0), ack);
    wr_byte(8'h40, ack);
    wr_byte(8'hEE, ack);
    bus_start();
    bus_stop();
    bus_start();
    wr_byte(addr_byte(9'h040, 1'b0), ack);
    chk(ack, "R6 no busy after empty STOP", ack, 1);
    bus_stop();
    do_read(9'h040, 1, "R6 abandoned data not stored");

    // R8: read wraps 0x1FF -> 0x000
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    do_write(9'h1FE, 2, 1'b1);
    do_read(9'h1FE, 4, "R8 read wrap across top");

    // R9: NACK ends read, line stays released
    bus_start();
    wr_byte(addr_byte(9'h1FE, 1'b0), ack);
    wr_byte(8'hFE, ack);
    bus_start();
    wr_byte(addr_byte(9'h1FE, 1'b1), ack);
    rd_byte(1'b0, v);
    chk(v == 8'hA1, "R9 byte before nack", v, 8'hA1);
    v = 8'h00;
    for (int i = 7; i >= 0; i--) begin bit_rx(b); v[i] = b; end
    chk(v == 8'hFF, "R9 released after nack", v, 8'hFF);
    chk(sda_oe == 1'b0, "R9 oe low after nack", sda_oe, 0);
    bus_stop();

    // random page writes and reads
    for (int k = 0; k < 5; k++) begin
      ra = 9'($urandom_range(0, 511));
      n  = $urandom_range(1, 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(ra, n, 1'b1);
      ra = 9'($urandom_range(0, 511));
      do_read(ra, $urandom_range(1, 12), "R8 random sequential read");
      do_read({ra[8:4], 4'h0}, 16, "R5 random page readback");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule